// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers up to eight interrupt request sources into one upstream interrupt line. Each source sets its bit in a pending register. A software-visible enable mask decides which pending bits may raise the line. Software reaches the block through a byte-wide register port with separate write and read selects. On the write side it can program the primary mask, program a secondary mask, or acknowledge one pending bit by index. On the read side it can fetch either mask, the pending register, or a secondary in-service register.

The primary mask uses inverted sense. Writing a 1 to a bit disables that source. The block keeps the complement internally as an enable vector, and a read returns the byte that was written. The secondary mask is only storage: it is kept as written, can be read back, and plays no part in raising the upstream line. The upstream line is a register. It follows whether any pending bit is also enabled, and it is updated on the clock edge that changes either operand.

Top module: `irq_mask_aggregator`

## Requirements
- R1: While reset is active and after it is released, the pending register is zero, the enable vector is zero (so a primary mask read returns all ones in the low NUM_SRC bits), the secondary mask is zero and irq_out is low.
- R2: A write with wr_sel = 0 stores the complement of wr_data (low NUM_SRC bits) as the enable vector, and a read with rd_sel = 0 returns the byte last written there (low NUM_SRC bits, upper bits zero).
- R3: On every clock edge each bit of req_in that is high is OR-ed into the pending register, and it is readable from the next cycle on.
- R4: A write with wr_sel = 2 clears the pending bit whose index is wr_data[3:0]; wr_data[7:4] is ignored, and an index of NUM_SRC or above clears nothing.
- R5: If a request and an acknowledge target the same bit in the same cycle, the bit stays pending.
- R6: From the cycle after any edge, irq_out is high exactly when the pending register AND the enable vector is nonzero, whether the change came from a mask write, an acknowledge or a new request.
- R7: A read with rd_sel = 3 returns the pending register, zero-extended to eight bits.
- R8: A read with rd_sel = 4 always returns zero.
- R9: A write with wr_sel = 1 stores wr_data unchanged as the secondary mask, a read with rd_sel = 1 returns it, and such a write never changes irq_out.
- R10: Writes with wr_sel of 3 to 7 change no state, and reads with rd_sel of 2 or 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_sel | input | 3 | Write target: 0 primary mask, 1 secondary mask, 2 acknowledge |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 3 | Read source: 0 primary mask, 1 secondary mask, 3 pending, 4 secondary in-service |
| rd_data | output | 8 | Read data for rd_sel, combinational from the registers |
| req_in | input | NUM_SRC | Request sources, sampled on every edge |
| irq_out | output | 1 | Upstream interrupt line |

## Verification
The bench targets an acknowledge that collides with a new request on the same bit. A design that let the clear win would drop an interrupt. The bench also sends acknowledge bytes whose high nibble is set or whose index lies beyond the sources. A design that decoded too many bits would either wipe the wrong bit or clear nothing. A mask read-back is checked so that a missing inversion shows up at once. The bench watches irq_out after a pending source is unmasked, after a pending source is masked, and after a secondary mask write. A line that only reacted to requests, or that took notice of the secondary mask, would stay stuck or toggle at the wrong moment.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int IDX_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_PMASK = 3'd0,
        SEL_SMASK = 3'd1,
        SEL_ACK   = 3'd2,
        SEL_PISR  = 3'd3,
        SEL_SISR  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] pending;
        logic [DATA_W-1:0] enable;
        logic [DATA_W-1:0] sec_mask;
        logic              irq;
    } agg_state_t;

endpackage

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
    import intr_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] clr_vec
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr_vec[i] = ack_valid && (ack_idx == IDX_W'(i));
    end

    always_comb begin
        if (ack_valid) begin
            a_r4_single_clear: assert ($countones(clr_vec) <= 1);
        end
    end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import intr_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [DATA_W-1:0] pending,
    input  logic [DATA_W-1:0] enable,
    input  logic [DATA_W-1:0] sec_mask,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'((1 << NUM_SRC) - 1);

    always_comb begin
        case (rd_sel)
            SEL_PMASK: rd_data = ~enable & SRC_MASK;
            SEL_SMASK: rd_data = sec_mask;
            SEL_PISR:  rd_data = pending & SRC_MASK;
            default:   rd_data = '0;
        endcase
    end

    always_comb begin
        if (rd_sel == SEL_SISR) begin
            a_r8_sec_isr_zero: assert (rd_data == '0);
        end
        if (rd_sel == SEL_ACK || rd_sel > SEL_SISR) begin
            a_r10_unused_read_zero: assert (rd_data == '0);
        end
    end

endmodule

// File: rtl/irq_mask_aggregator.sv
module irq_mask_aggregator
    import intr_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] req_in,
    output logic               irq_out
);

    localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'((1 << NUM_SRC) - 1);

    agg_state_t          st_d, st_q;
    logic                ack_valid;
    logic [NUM_SRC-1:0]  ack_clr;
    logic [DATA_W-1:0]   clr_ext;
    logic [DATA_W-1:0]   req_ext;

    assign ack_valid = wr_en && (wr_sel == SEL_ACK);
    assign clr_ext   = DATA_W'(ack_clr);
    assign req_ext   = DATA_W'(req_in);

    irq_ack_decode #(
        .NUM_SRC (NUM_SRC)
    ) u_ack_decode (
        .ack_valid (ack_valid),
        .ack_idx   (wr_data[IDX_W-1:0]),
        .clr_vec   (ack_clr)
    );

    // Next-state process: requests are OR-ed after the clear so a set wins.
    always_comb begin
        st_d = st_q;
        if (wr_en && wr_sel == SEL_PMASK) begin
            st_d.enable = ~wr_data & SRC_MASK;
        end
        if (wr_en && wr_sel == SEL_SMASK) begin
            st_d.sec_mask = wr_data;
        end
        st_d.pending = ((st_q.pending & ~clr_ext) | req_ext) & SRC_MASK;
        st_d.irq     = |(st_d.pending & st_d.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    irq_read_mux #(
        .NUM_SRC (NUM_SRC)
    ) u_read_mux (
        .rd_sel   (rd_sel),
        .pending  (st_q.pending),
        .enable   (st_q.enable),
        .sec_mask (st_q.sec_mask),
        .rd_data  (rd_data)
    );

    assign irq_out = st_q.irq;

    a_r2_mask_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PMASK) |=> (rd_sel != SEL_PMASK ||
            rd_data == ($past(wr_data) & SRC_MASK)));

    a_r3_req_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_in) |=> ((st_q.pending & DATA_W'($past(req_in))) == DATA_W'($past(req_in))));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_clr) && ((ack_clr & req_in) == '0))
            |=> ((st_q.pending & DATA_W'($past(ack_clr))) == '0));

    a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(st_q.pending & st_q.enable)));

    a_r9_smask_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SMASK) |=> (st_q.sec_mask == $past(wr_data)));

endmodule

// File: tb/irq_mask_aggregator_bench.sv
module irq_mask_aggregator_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 8;
    localparam int SRCM       = (1 << NSRC) - 1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic [2:0]      wr_sel;
    logic [7:0]      wr_data;
    logic [2:0]      rd_sel;
    logic [7:0]      rd_data;
    logic [NSRC-1:0] req_in;
    logic            irq_out;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    int m_pend  = 0;
    int m_en    = 0;
    int m_smask = 0;
    bit m_irq   = 0;

    irq_mask_aggregator #(.NUM_SRC(NSRC)) u_irq_mask_aggregator (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .req_in  (req_in),
        .irq_out (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_read(input int sel);
        case (sel)
            0: return (~m_en) & SRCM;
            1: return m_smask;
            3: return m_pend;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input int sel);
        case (sel)
            0: return "R2";
            1: return "R9";
            3: return "R7";
            4: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input int sel, input int data, input int req,
                        input int rsel, input string tag);
        int clr;
        wr_en   = we;
        wr_sel  = 3'(sel);
        wr_data = 8'(data);
        req_in  = NSRC'(req);
        rd_sel  = 3'(rsel);
        @(posedge clk);
        clr = 0;
        if (we && sel == 2 && (data & 15) < NSRC) clr = 1 << (data & 15);
        m_pend = ((m_pend & ~clr) | req) & SRCM;
        if (we && sel == 0) m_en = (~data) & SRCM;
        if (we && sel == 1) m_smask = data & 255;
        m_irq = (m_pend & m_en) != 0;
        @(negedge clk);
        check(tag, int'(rd_data), model_read(rsel));
        check("R6 irq_out", int'(irq_out), int'(m_irq));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; req_in = '0; rd_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state, checked through each read path
        rd_sel = 3'd0; #1 check("R1 mask read", int'(rd_data), SRCM);
        rd_sel = 3'd1; #1 check("R1 sec mask", int'(rd_data), 0);
        rd_sel = 3'd3; #1 check("R1 pending", int'(rd_data), 0);
        check("R1 irq", int'(irq_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        step(1, 0, 8'h0F, 0,     0, "R2 mask readback");
        step(0, 0, 0,     8'h01, 3, "R3 masked request");
        step(0, 0, 0,     8'h10, 3, "R3 enabled request");
        step(1, 2, 8'hF4, 0,     3, "R4 ack high nibble ignored");
        step(1, 2, 8'h00, 8'h01, 3, "R5 set wins over ack");
        step(1, 2, 8'h09, 0,     3, "R4 ack index out of range");
        step(1, 0, 8'h00, 0,     0, "R2 unmask all");
        step(1, 1, 8'hFF, 0,     1, "R9 secondary mask stored");
        step(1, 2, 8'h00, 0,     3, "R4 ack last bit");
        step(1, 3, 8'hAA, 0,     3, "R10 write to read-only select");
        step(0, 0, 0,     8'h80, 4, "R8 secondary in-service zero");
        step(1, 0, 8'hFF, 0,     0, "R2 mask all");
        step(1, 1, 8'h00, 0,     1, "R9 secondary mask no irq effect");
        step(0, 0, 0,     0,     2, "R10 unused read");
        step(1, 0, 8'h7F, 0,     3, "R6 unmask pending bit");
        step(1, 2, 8'h07, 8'h80, 3, "R5 set wins on high bit");

        for (int i = 0; i < 600; i++) begin
            int rs;
            rs = int'($urandom_range(0, 7));
            step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 255)),
                 int'($urandom & $urandom & $urandom) & SRCM, rs, tag_for(rs));
        end

        wr_en = 1'b0; req_in = '0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule